// File: doc/BRIEF.md
# Variable-Length Voice Serial Port

This block is a full-duplex serial port that carries compressed voice words between a codec core and two serial links. Each direction has its own bit clock and frame sync. The block samples all serial inputs into the system clock domain and finds the clock edges there.

On the receive side, the frame sync sets the word length for that frame. The block counts the falling bit-clock edges seen while sync is high. A count of 2, 3 or 4 selects 16, 24 or 32 kbps ADPCM decoding, and a count of 8 selects 64 kbps PCM. The word is shifted in MSB first. When the sync ends, the block presents the word together with its decode mode and raises a one-cycle ready pulse for the core. Any other count discards the word and sets a sticky error flag.

On the transmit side, the block shifts out a word of the programmed length MSB first. The output enable is held by a bit counter, not by the sync. The pin is driven for the word length less half a bit clock, even when the sync ends early. Between words the pin is released.

Top module: `vsp_port`

## Requirements
- R1: After reset, tx_oe, tx_data, rx_ready, rx_err, rx_word and rx_mode are all 0.
- R2: The receive word length is the number of falling rx_bclk edges seen while rx_sync is high. Lengths 2, 3, 4 and 8 give rx_mode codes 0, 1, 2 and 3 (ADPCM 16, 24 and 32 kbps, and PCM 64 kbps).
- R3: Receive bits are sampled on falling rx_bclk edges, MSB first. The word is right-aligned in rx_word, and the bits above the word length are 0.
- R4: Each valid receive word gives exactly one rx_ready pulse, one system clock wide, after rx_sync falls. rx_word and rx_mode change only on that pulse.
- R5: A receive length other than 2, 3, 4 or 8 gives no rx_ready pulse and leaves rx_word and rx_mode unchanged. It sets rx_err, which stays 1 until reset.
- R6: The receive length and mode may change from one frame to the next.
- R7: A transmit word starts on the first rising tx_bclk edge at which tx_sync is high. At that edge the block drives the MSB of tx_word and raises tx_oe. Each later rising edge drives the next lower bit. tx_len uses the same 0 to 3 code as rx_mode: 2, 3, 4 and 8 bits.
- R8: tx_oe stays 1 for the word length less half a bit clock. It falls on the falling tx_bclk edge inside the last bit.
- R9: The transmit drive lasts the full word even if tx_sync falls before the last bit.
- R10: After a word, no new word starts until tx_sync has been low. tx_data is 0 whenever tx_oe is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times either bit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_bclk | input | 1 | Receive bit clock |
| rx_sync | input | 1 | Receive frame sync, active high; its length sets the word length |
| rx_data | input | 1 | Receive serial data |
| rx_word | output | 8 | Last valid received word, right-aligned |
| rx_mode | output | 2 | Decode mode of rx_word (0..3) |
| rx_ready | output | 1 | One-cycle pulse when a valid word is presented |
| rx_err | output | 1 | Sticky flag for a frame of illegal length |
| tx_bclk | input | 1 | Transmit bit clock |
| tx_sync | input | 1 | Transmit frame sync, active high |
| tx_word | input | 8 | Word to send, right-aligned |
| tx_len | input | 2 | Transmit length code (0..3) |
| tx_data | output | 1 | Transmit serial data |
| tx_oe | output | 1 | Output enable of the transmit pad driver |

## Verification
The assertions assume that each bit clock runs at no more than a quarter of the system clock, so that every edge appears in the synchronizers as a separate event. They also assume that sync and data change only near rising bit-clock edges, and that tx_word and tx_len are stable when a word starts. The bench keeps within these limits. It uses a bit clock twelve system clocks long and changes sync, data and clock together on system clock falling edges. It sets the transmit word and length before it raises the sync.

// File: rtl/vsp_pkg.sv
package vsp_pkg;
  localparam int WORD_W = 8;
  localparam int CNT_W  = 4;

  typedef enum logic [1:0] {
    MODE_ADPCM16 = 2'd0,
    MODE_ADPCM24 = 2'd1,
    MODE_ADPCM32 = 2'd2,
    MODE_PCM64   = 2'd3
  } vsp_mode_e;

  // word length in bits for a mode code
  function automatic logic [CNT_W-1:0] len_of_mode(vsp_mode_e m);
    case (m)
      MODE_ADPCM16: return CNT_W'(2);
      MODE_ADPCM24: return CNT_W'(3);
      MODE_ADPCM32: return CNT_W'(4);
      default:      return CNT_W'(8);
    endcase
  endfunction

  function automatic logic len_valid(logic [CNT_W-1:0] n);
    return (n == CNT_W'(2)) || (n == CNT_W'(3)) ||
           (n == CNT_W'(4)) || (n == CNT_W'(8));
  endfunction

  function automatic vsp_mode_e mode_of_len(logic [CNT_W-1:0] n);
    case (n)
      CNT_W'(3): return MODE_ADPCM24;
      CNT_W'(4): return MODE_ADPCM32;
      CNT_W'(8): return MODE_PCM64;
      default:   return MODE_ADPCM16;
    endcase
  endfunction

  // ones in the low len bits
  function automatic logic [WORD_W-1:0] low_mask(vsp_mode_e m);
    logic [WORD_W:0] t;
    t = (WORD_W+1)'(1) << len_of_mode(m);
    t = t - (WORD_W+1)'(1);
    return t[WORD_W-1:0];
  endfunction

  // moves the word's MSB to bit WORD_W-1
  function automatic logic [WORD_W-1:0] left_align(logic [WORD_W-1:0] w, vsp_mode_e m);
    logic [CNT_W-1:0] sh;
    sh = CNT_W'(WORD_W) - len_of_mode(m);
    return w << sh;
  endfunction
endpackage

// File: rtl/vsp_sync.sv
module vsp_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage[g] <= '0;
      else if (g == 0) stage[g] <= d;
      else stage[g] <= stage[(g == 0) ? 0 : g-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/vsp_rx.sv
module vsp_rx
  import vsp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bclk_fall,
  input  logic              sync_lvl,
  input  logic              sync_fall,
  input  logic              data_lvl,
  output logic [WORD_W-1:0] word,
  output logic [1:0]        mode,
  output logic              ready,
  output logic              err
);
  logic [WORD_W-1:0] shreg;
  logic [CNT_W-1:0]  cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      cnt   <= '0;
      word  <= '0;
      mode  <= '0;
      ready <= 1'b0;
      err   <= 1'b0;
    end else begin
      ready <= 1'b0;
      if (sync_fall) begin
        if (len_valid(cnt)) begin
          word  <= shreg & low_mask(mode_of_len(cnt));
          mode  <= mode_of_len(cnt);
          ready <= 1'b1;
        end else begin
          err <= 1'b1;
        end
        cnt   <= '0;
        shreg <= '0;
      end else if (bclk_fall && sync_lvl) begin
        shreg <= {shreg[WORD_W-2:0], data_lvl};
        if (cnt != '1) cnt <= cnt + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/vsp_tx.sv
module vsp_tx
  import vsp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bclk_rise,
  input  logic              bclk_fall,
  input  logic              sync_lvl,
  input  logic [WORD_W-1:0] word_in,
  input  logic [1:0]        len_code,
  output logic              data,
  output logic              oe
);
  logic [WORD_W-1:0] shreg;
  logic [CNT_W-1:0]  rem;
  logic              armed;
  logic              start;
  logic [WORD_W-1:0] aligned;

  assign start   = bclk_rise && !oe && armed && sync_lvl;
  assign aligned = left_align(word_in, vsp_mode_e'(len_code));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      rem   <= '0;
      armed <= 1'b0;
      data  <= 1'b0;
      oe    <= 1'b0;
    end else begin
      if (!sync_lvl) armed <= 1'b1;
      if (start) begin
        shreg <= aligned;
        data  <= aligned[WORD_W-1];
        rem   <= len_of_mode(vsp_mode_e'(len_code)) - CNT_W'(1);
        oe    <= 1'b1;
        armed <= 1'b0;
      end else if (bclk_rise && oe && rem != '0) begin
        shreg <= shreg << 1;
        data  <= shreg[WORD_W-2];
        rem   <= rem - CNT_W'(1);
      end else if (bclk_fall && oe && rem == '0) begin
        oe   <= 1'b0;
        data <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/vsp_port.sv
module vsp_port
  import vsp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_bclk,
  input  logic              rx_sync,
  input  logic              rx_data,
  output logic [WORD_W-1:0] rx_word,
  output logic [1:0]        rx_mode,
  output logic              rx_ready,
  output logic              rx_err,
  input  logic              tx_bclk,
  input  logic              tx_sync,
  input  logic [WORD_W-1:0] tx_word,
  input  logic [1:0]        tx_len,
  output logic              tx_data,
  output logic              tx_oe
);
  logic [2:0] rx_s;
  logic [1:0] tx_s;
  logic       rx_bclk_s, rx_sync_s, rx_data_s, tx_bclk_s, tx_sync_s;
  logic       rx_bclk_d, rx_sync_d, tx_bclk_d;

  // named edge events, also watched by the checker
  logic       rx_bclk_fall, rx_sync_fall, tx_bclk_rise, tx_bclk_fall;

  vsp_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_rx_sync (
    .clk(clk), .rst_n(rst_n), .d({rx_bclk, rx_sync, rx_data}), .q(rx_s));
  vsp_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_tx_sync (
    .clk(clk), .rst_n(rst_n), .d({tx_bclk, tx_sync}), .q(tx_s));

  assign {rx_bclk_s, rx_sync_s, rx_data_s} = rx_s;
  assign {tx_bclk_s, tx_sync_s}            = tx_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_bclk_d <= 1'b0;
      rx_sync_d <= 1'b0;
      tx_bclk_d <= 1'b0;
    end else begin
      rx_bclk_d <= rx_bclk_s;
      rx_sync_d <= rx_sync_s;
      tx_bclk_d <= tx_bclk_s;
    end
  end

  assign rx_bclk_fall = rx_bclk_d & ~rx_bclk_s;
  assign rx_sync_fall = rx_sync_d & ~rx_sync_s;
  assign tx_bclk_rise = tx_bclk_s & ~tx_bclk_d;
  assign tx_bclk_fall = tx_bclk_d & ~tx_bclk_s;

  vsp_rx u_rx (
    .clk(clk), .rst_n(rst_n), .bclk_fall(rx_bclk_fall), .sync_lvl(rx_sync_s),
    .sync_fall(rx_sync_fall), .data_lvl(rx_data_s), .word(rx_word),
    .mode(rx_mode), .ready(rx_ready), .err(rx_err));

  vsp_tx u_tx (
    .clk(clk), .rst_n(rst_n), .bclk_rise(tx_bclk_rise), .bclk_fall(tx_bclk_fall),
    .sync_lvl(tx_sync_s), .word_in(tx_word), .len_code(tx_len),
    .data(tx_data), .oe(tx_oe));
endmodule

// File: rtl/vsp_checker.sv
module vsp_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] rx_word,
  input logic [1:0] rx_mode,
  input logic       rx_ready,
  input logic       rx_err,
  input logic       rx_sync_fall,
  input logic       tx_bclk_rise,
  input logic       tx_bclk_fall,
  input logic       tx_sync_s,
  input logic       tx_data,
  input logic       tx_oe
);
  assert_ready_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready |=> !rx_ready);
  assert_ready_after_sync_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready |-> $past(rx_sync_fall));
  assert_word_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_ready |-> ($stable(rx_word) && $stable(rx_mode)));
  assert_err_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_err |=> rx_err);
  assert_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ready && rx_mode != 2'd3) |-> (rx_word[7:4] == 4'd0));
  assert_start_on_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_oe) |-> $past(tx_bclk_rise && tx_sync_s));
  assert_end_on_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_oe) |-> $past(tx_bclk_fall));
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_oe |-> !tx_data);
endmodule

bind vsp_port vsp_checker u_vsp_checker (
  .clk(clk), .rst_n(rst_n), .rx_word(rx_word), .rx_mode(rx_mode),
  .rx_ready(rx_ready), .rx_err(rx_err), .rx_sync_fall(rx_sync_fall),
  .tx_bclk_rise(tx_bclk_rise), .tx_bclk_fall(tx_bclk_fall),
  .tx_sync_s(tx_sync_s), .tx_data(tx_data), .tx_oe(tx_oe));

// File: tb/vsp_port_bench.sv
`timescale 1ns/1ps
module vsp_port_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_bclk = 1'b0, rx_sync = 1'b0, rx_data = 1'b0;
  logic [7:0] rx_word;
  logic [1:0] rx_mode;
  logic       rx_ready, rx_err;
  logic       tx_bclk = 1'b0, tx_sync = 1'b0;
  logic [7:0] tx_word = 8'h00;
  logic [1:0] tx_len = 2'd0;
  logic       tx_data, tx_oe;

  int n_tests = 0;
  int n_fail  = 0;
  int rdy_cnt = 0;
  logic [7:0] cap_word = 8'h00;
  logic [1:0] cap_mode = 2'd0;

  localparam int HALF = 6; // system clocks per bit-clock phase

  always #4 clk = ~clk;

  vsp_port u_vsp_port (
    .clk(clk), .rst_n(rst_n), .rx_bclk(rx_bclk), .rx_sync(rx_sync),
    .rx_data(rx_data), .rx_word(rx_word), .rx_mode(rx_mode),
    .rx_ready(rx_ready), .rx_err(rx_err), .tx_bclk(tx_bclk),
    .tx_sync(tx_sync), .tx_word(tx_word), .tx_len(tx_len),
    .tx_data(tx_data), .tx_oe(tx_oe));

  always @(negedge clk) begin
    if (rst_n && rx_ready) begin
      rdy_cnt  <= rdy_cnt + 1;
      cap_word <= rx_word;
      cap_mode <= rx_mode;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int bits_of(input int code);
    return (code == 0) ? 2 : (code == 1) ? 3 : (code == 2) ? 4 : 8;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 tx_oe", int'(tx_oe), 0);
    check("R1 tx_data", int'(tx_data), 0);
    check("R1 rx_ready", int'(rx_ready), 0);
    check("R1 rx_err", int'(rx_err), 0);
    check("R1 rx_word", int'(rx_word), 0);
    check("R1 rx_mode", int'(rx_mode), 0);
  endtask

  task automatic rx_bit(input logic s, input logic d);
    rx_sync = s; rx_data = d; rx_bclk = 1'b1;
    repeat (HALF) @(negedge clk);
    rx_bclk = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  // sends n bits of val with sync high for exactly n bit clocks
  task automatic rx_frame(input int n, input int val, input logic good, input int code);
    int before_cnt;
    logic [7:0] before_word;
    before_cnt  = rdy_cnt;
    before_word = rx_word;
    for (int i = 0; i < n; i++) rx_bit(1'b1, val[n-1-i]);
    rx_bit(1'b0, 1'b0);
    rx_bit(1'b0, 1'b0);
    if (good) begin
      check("R4 one ready pulse", rdy_cnt - before_cnt, 1);
      check("R3 word value", int'(cap_word), val & ((1 << n) - 1));
      check("R2 mode code", int'(cap_mode), code);
    end else begin
      check("R5 no ready pulse", rdy_cnt - before_cnt, 0);
      check("R5 word unchanged", int'(rx_word), int'(before_word));
      check("R5 err set", int'(rx_err), 1);
    end
  endtask

  // sync_cycles: bit clocks with tx_sync high (at least 1)
  task automatic tx_frame(input int code, input int val, input int sync_cycles, input string req);
    int n, total;
    n = bits_of(code);
    tx_len  = code[1:0];
    tx_word = val[7:0];
    total = ((sync_cycles > n) ? sync_cycles : n) + 1;
    for (int i = 0; i < total; i++) begin
      tx_sync = (i < sync_cycles);
      tx_bclk = 1'b1;
      repeat (HALF - 1) @(negedge clk);
      if (i < n) begin
        check({req, " oe high phase"}, int'(tx_oe), 1);
        check({req, " R7 bit"}, int'(tx_data), val[n-1-i]);
      end else begin
        check({req, " R10 idle oe"}, int'(tx_oe), 0);
      end
      @(negedge clk);
      tx_bclk = 1'b0;
      repeat (HALF - 1) @(negedge clk);
      if (i < n - 1) check({req, " R8 oe low phase"}, int'(tx_oe), 1);
      else begin
        check({req, " R8 released"}, int'(tx_oe), 0);
        check({req, " R10 data zero"}, int'(tx_data), 0);
      end
      @(negedge clk);
    end
  endtask

  task automatic test_rx_lengths();
    rx_frame(2, 2'b10, 1'b1, 0);       // R2 16 kbps
    rx_frame(3, 3'b101, 1'b1, 1);      // R2 24 kbps
    rx_frame(4, 4'b0110, 1'b1, 2);     // R2 32 kbps
    rx_frame(8, 8'hA7, 1'b1, 3);       // R2 64 kbps PCM
    check("R5 err clear after good", int'(rx_err), 0);
  endtask

  task automatic test_rx_frame_change();
    rx_frame(8, 8'h3C, 1'b1, 3);       // R6 long then short
    rx_frame(2, 2'b01, 1'b1, 0);
    check("R3 upper bits zero", int'(rx_word[7:2]), 0);
    rx_frame(4, 4'b1001, 1'b1, 2);
  endtask

  task automatic test_rx_bad();
    rx_frame(5, 5'b10110, 1'b0, 0);    // R5 illegal length
    rx_frame(1, 1'b1, 1'b0, 0);
    rx_frame(3, 3'b011, 1'b1, 1);      // still decodes afterwards
    check("R5 err sticky", int'(rx_err), 1);
  endtask

  task automatic test_tx();
    tx_frame(0, 8'h02, 2, "R7 len2");
    tx_frame(1, 8'h05, 3, "R7 len3");
    tx_frame(2, 8'h0B, 4, "R7 len4");
    tx_frame(3, 8'hC5, 8, "R7 len8");
    tx_frame(3, 8'h96, 1, "R9 early sync drop len8");
    tx_frame(2, 8'h06, 2, "R9 early sync drop len4");
    tx_frame(0, 8'h03, 5, "R10 sync held long");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    test_rx_lengths();
    test_rx_frame_change();
    test_tx();
    test_rx_bad();
    do_reset();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule